// File: doc/BRIEF.md
# Programmable Weighted Round-Robin Queue Sequencer

This block decides which egress queue of a switch port is served next. Rather than keeping a weight counter per queue, it steps through a programmable table of queue numbers, one slot per grant. Each time the transmit side raises a request, the block grants the queue named in the current slot. If that queue has nothing to send, the block moves on to the next slot, in the same cycle, whose queue does have data.

The table holds up to 128 slots and is loaded through a 16-bit configuration word. Bit 15 of the word starts an update, and bits 14:8 select a group of slots. In narrow mode there are four queues, and each word fills four consecutive slots with 2-bit queue numbers. In wide mode there are eight queues, and each word fills two consecutive slots with 3-bit queue numbers. A reserved group value sets how many slots are active.

After reset the table holds a 15-slot pattern for four queues. Queue 3 is served on every other slot, queue 2 on every fourth, queue 1 on every eighth, and queue 0 once. The higher queue number always carries the higher priority.

Top module: `wrr_sequencer`

## Requirements
- R1: After reset, grant_vld and cfg_busy are 0, the active length is 15, the read pointer is at slot 0, and slots 0..14 hold the queue numbers 3,2,3,1,3,2,3,0,3,2,3,1,3,2,3.
- R2: With every candidate queue non-empty, successive requests grant the slots in ascending order. After the slot at length minus one, the next grant comes from slot 0.
- R3: A request grants the first slot at or after the read pointer, wrapping at the length, whose queue's flag in q_nonempty is 1. The pointer then moves to the slot after the granted one.
- R4: A request while no slot names a non-empty queue leaves grant_vld at 0 and the read pointer unchanged.
- R5: grant_vld and grant_q are registered. They reflect the request sampled at the previous rising edge, and a cycle without a request gives grant_vld 0.
- R6: In narrow mode (mode_wide=0), an accepted word with group g < 32 writes slots 4g..4g+3 with bits 1:0, 3:2, 5:4 and 7:6, in that order.
- R7: In wide mode (mode_wide=1), an accepted word with group g < 64 writes slots 2g and 2g+1 with bits 2:0 and 6:4.
- R8: An accepted word whose group field equals 32 in narrow mode, or 64 in wide mode, sets the active length to bits 7:0 and returns the read pointer to slot 0. The length must be in the range 1..128; any other value is ignored.
- R9: A word is accepted only when cfg_we=1, bit 15 is 1 and cfg_busy=0. Acceptance raises cfg_busy for exactly the next cycle, and words offered while busy or with bit 15 at 0 change nothing.
- R10: In narrow mode only the low two bits of a slot and the flags q_nonempty[3:0] are used, so grant_q never exceeds 3.
- R11: An accepted word whose group lies above the length-select value of the current mode writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 0: four queues, 2-bit slots; 1: eight queues, 3-bit slots |
| cfg_we | input | 1 | Configuration word strobe |
| cfg_wdata | input | 16 | Configuration word: [15] update, [14:8] group, [7:0] payload |
| cfg_busy | output | 1 | High for one cycle after an accepted word |
| q_nonempty | input | 8 | Per-queue has-data flags |
| req | input | 1 | Grant request strobe |
| grant_vld | output | 1 | A grant was made for the previous request |
| grant_q | output | 3 | Granted queue number |

## Verification
The assertions assume that mode_wide changes only while no request is pending and no configuration word is in flight. They also assume that q_nonempty and req are stable around the clock edge. The bench changes the mode only between phases, with req low, and drives all inputs on the falling edge. It waits for cfg_busy to drop before offering a new word, except in the one step that deliberately writes while busy. The grant-source assertion compares grant_q with the flags sampled at the request edge, which relies on those flags being held for that edge.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_SLOTS = 2'd1,
    CMD_LEN   = 2'd2
  } cfg_cmd_e;

  localparam int BOOT_LEN = 15;

  // Boot pattern: queue = 3 - (number of trailing zeros of slot+1)
  function automatic logic [2:0] boot_entry(input int s);
    int v;
    int tz;
    v  = s + 1;
    tz = 0;
    if (s >= BOOT_LEN) return 3'd0;
    for (int b = 0; b < 4; b++) begin
      if ((((v >> b) & 1) == 0) && (tz == b)) tz = b + 1;
    end
    return 3'(3 - tz);
  endfunction
endpackage

// File: rtl/wrr_cfg_port.sv
module wrr_cfg_port
  import wrr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 7,
  parameter int PAY_W  = 8,
  parameter int NSLOT  = 128,
  parameter int SEL_N  = 32,
  parameter int SEL_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wide,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output cfg_cmd_e          cmd,
  output logic [PTR_W-1:0]  grp,
  output logic [PAY_W-1:0]  payload
);
  logic             accept;
  logic [PTR_W-1:0] len_sel;

  assign accept  = we && wdata[DATA_W-1] && !busy;
  assign grp     = wdata[DATA_W-2 -: PTR_W];
  assign payload = wdata[PAY_W-1:0];
  assign len_sel = mode_wide ? PTR_W'(SEL_W) : PTR_W'(SEL_N);

  always_comb begin
    cmd = CMD_NONE;
    if (accept) begin
      if (grp == len_sel) begin
        if (payload != '0 && int'(payload) <= NSLOT) cmd = CMD_LEN;
      end else if (grp < len_sel) begin
        cmd = CMD_SLOTS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= accept;
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R9
endmodule

// File: rtl/wrr_seq_table.sv
module wrr_seq_table
  import wrr_pkg::*;
#(
  parameter int NSLOT = 128,
  parameter int QW    = 3,
  parameter int PTR_W = 7,
  parameter int LEN_W = 8,
  parameter int PAY_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_wide,
  input  cfg_cmd_e              cmd,
  input  logic [PTR_W-1:0]      grp,
  input  logic [PAY_W-1:0]      payload,
  output logic [NSLOT*QW-1:0]   entries,
  output logic [LEN_W-1:0]      len
);
  localparam int NW     = QW - 1;
  localparam int PER_N  = PAY_W / NW;
  localparam int STRIDE = QW + 1;
  localparam int PER_W  = PAY_W / STRIDE;

  logic [QW-1:0] tbl [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) tbl[s] <= QW'(boot_entry(s));
      len <= LEN_W'(BOOT_LEN);
    end else begin
      if (cmd == CMD_SLOTS) begin
        if (!mode_wide) begin
          for (int k = 0; k < PER_N; k++)
            tbl[PTR_W'(int'(grp) * PER_N + k)] <= QW'(payload[k*NW +: NW]);
        end else begin
          for (int k = 0; k < PER_W; k++)
            tbl[PTR_W'(int'(grp) * PER_W + k)] <= payload[k*STRIDE +: QW];
        end
      end
      if (cmd == CMD_LEN) len <= LEN_W'(payload);
    end
  end

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_flat
      assign entries[s*QW +: QW] = tbl[s];
    end
  endgenerate

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (len != '0) && (int'(len) <= NSLOT)); // R8
endmodule

// File: rtl/wrr_pick.sv
module wrr_pick #(
  parameter int NSLOT = 128,
  parameter int QW    = 3,
  parameter int NQ    = 8,
  parameter int PTR_W = 7,
  parameter int LEN_W = 8
) (
  input  logic [NSLOT*QW-1:0] entries,
  input  logic [LEN_W-1:0]    len,
  input  logic [PTR_W-1:0]    ptr,
  input  logic                mode_wide,
  input  logic [NQ-1:0]       nonempty,
  output logic                found,
  output logic [PTR_W-1:0]    slot,
  output logic [QW-1:0]       queue
);
  localparam logic [QW-1:0] NARROW_MASK = QW'((1 << (QW - 1)) - 1);

  logic [NSLOT-1:0] hit;
  logic [QW-1:0]    qsel [NSLOT];

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [QW-1:0] raw;
      assign raw     = entries[i*QW +: QW];
      assign qsel[i] = mode_wide ? raw : (raw & NARROW_MASK);
      assign hit[i]  = (LEN_W'(i) < len) && nonempty[qsel[i]];
    end
  endgenerate

  // First hit at or after ptr; otherwise first hit from slot 0 (wrap)
  always_comb begin
    logic             up_f;
    logic [PTR_W-1:0] up_s;
    logic [PTR_W-1:0] lo_s;
    up_f  = 1'b0;
    found = 1'b0;
    up_s  = '0;
    lo_s  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        lo_s  = PTR_W'(i);
        if (PTR_W'(i) >= ptr) begin
          up_f = 1'b1;
          up_s = PTR_W'(i);
        end
      end
    end
    slot  = up_f ? up_s : lo_s;
    queue = qsel[slot];
  end
endmodule

// File: rtl/wrr_sequencer.sv
module wrr_sequencer
  import wrr_pkg::*;
#(
  parameter int NQ     = 8,
  parameter int NSLOT  = 128,
  parameter int DATA_W = 16,
  parameter int PAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wide,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              cfg_busy,
  input  logic [NQ-1:0]     q_nonempty,
  input  logic              req,
  output logic              grant_vld,
  output logic [$clog2(NQ)-1:0] grant_q
);
  localparam int QW    = $clog2(NQ);
  localparam int PTR_W = $clog2(NSLOT);
  localparam int LEN_W = PTR_W + 1;
  localparam int SEL_N = NSLOT / (PAY_W / (QW - 1));
  localparam int SEL_W = NSLOT / (PAY_W / (QW + 1));

  cfg_cmd_e                cmd;
  logic [PTR_W-1:0]        grp;
  logic [PAY_W-1:0]        payload;
  logic [NSLOT*QW-1:0]     entries;
  logic [LEN_W-1:0]        len;
  logic [PTR_W-1:0]        ptr;
  logic                    found;
  logic [PTR_W-1:0]        slot;
  logic [QW-1:0]           pick_q;
  logic [LEN_W-1:0]        slot_nx;

  wrr_cfg_port #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .PAY_W(PAY_W),
    .NSLOT(NSLOT), .SEL_N(SEL_N), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .we(cfg_we),
    .wdata(cfg_wdata), .busy(cfg_busy), .cmd(cmd), .grp(grp),
    .payload(payload)
  );

  wrr_seq_table #(
    .NSLOT(NSLOT), .QW(QW), .PTR_W(PTR_W), .LEN_W(LEN_W), .PAY_W(PAY_W)
  ) u_tbl (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .cmd(cmd), .grp(grp),
    .payload(payload), .entries(entries), .len(len)
  );

  wrr_pick #(
    .NSLOT(NSLOT), .QW(QW), .NQ(NQ), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_pick (
    .entries(entries), .len(len), .ptr(ptr), .mode_wide(mode_wide),
    .nonempty(q_nonempty), .found(found), .slot(slot), .queue(pick_q)
  );

  assign slot_nx = LEN_W'(slot) + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      grant_vld <= 1'b0;
      grant_q   <= '0;
    end else begin
      grant_vld <= req && found;
      if (req && found) grant_q <= pick_q;
      if (cmd == CMD_LEN)
        ptr <= '0;
      else if (req && found)
        ptr <= (slot_nx == len) ? '0 : PTR_W'(slot_nx);
    end
  end

  AST_GRANT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> $past(req)); // R5
  AST_GRANT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> ((($past(q_nonempty) >> grant_q) & NQ'(1)) != '0)); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(req) && ($past(q_nonempty) == '0)) |-> !grant_vld); // R4
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    LEN_W'(ptr) < len); // R2
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !$past(mode_wide)) |-> (int'(grant_q) < NQ / 2)); // R10
endmodule

// File: tb/wrr_sequencer_bench.sv
module wrr_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wide = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_busy;
  logic [7:0]  q_nonempty = '0;
  logic        req = 1'b0;
  logic        grant_vld;
  logic [2:0]  grant_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wrr_sequencer u_wrr_sequencer (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_busy(cfg_busy), .q_nonempty(q_nonempty),
    .req(req), .grant_vld(grant_vld), .grant_q(grant_q)
  );

  // {nonempty[7:0], expected valid, expected queue[2:0]} on the boot table
  localparam int NV = 19;
  localparam bit [11:0] VEC [NV] = '{
    {8'h0F, 1'b1, 3'd3}, {8'h0F, 1'b1, 3'd2}, {8'h0F, 1'b1, 3'd3},
    {8'h0F, 1'b1, 3'd1}, {8'h03, 1'b1, 3'd0}, {8'h00, 1'b0, 3'd0},
    {8'h04, 1'b1, 3'd2}, {8'h02, 1'b1, 3'd1}, {8'h01, 1'b1, 3'd0},
    {8'h0F, 1'b1, 3'd3}, {8'h0F, 1'b1, 3'd2}, {8'h0F, 1'b1, 3'd3},
    {8'h0F, 1'b1, 3'd1}, {8'h0F, 1'b1, 3'd3}, {8'h0F, 1'b1, 3'd2},
    {8'h0F, 1'b1, 3'd3}, {8'h0F, 1'b1, 3'd3}, {8'hF0, 1'b0, 3'd0},
    {8'h0F, 1'b1, 3'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic gnt(input string tag, input logic [7:0] ne,
                     input logic ev, input logic [2:0] eq);
    @(negedge clk);
    q_nonempty = ne;
    req = 1'b1;
    @(posedge clk);
    #1;
    req = 1'b0;
    chk({tag, " vld"}, int'(grant_vld), int'(ev));
    if (ev) chk({tag, " q"}, int'(grant_q), int'(eq));
  endtask

  task automatic wr(input string tag, input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    chk({tag, " R9 busy set"}, int'(cfg_busy), int'(w[15]));
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk);
    #1;
    chk({tag, " R9 busy clear"}, int'(cfg_busy), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vld", int'(grant_vld), 0);
    chk("R1 reset busy", int'(cfg_busy), 0);
    @(negedge clk);
    rst = 1'b0;

    // Boot table walk: R1 pattern, R2 wrap at 15, R3 skip, R4 idle, R10 high flags
    for (int i = 0; i < NV; i++)
      gnt($sformatf("R1/R2/R3/R4/R10 vec%0d", i), VEC[i][11:4], VEC[i][3], VEC[i][2:0]);

    // R5: no request, no grant
    @(negedge clk);
    q_nonempty = 8'h0F;
    req = 1'b0;
    @(posedge clk);
    #1;
    chk("R5 no req", int'(grant_vld), 0);

    // R6 narrow write: group0 = 0,1,2,3 ; group1 = 3,3,3,3 ; R8 length 6
    wr("R6 g0", 16'h80E4);
    wr("R6 g1", 16'h81FF);
    wr("R8 len6", 16'hA006);
    gnt("R6 s0", 8'h0F, 1'b1, 3'd0);
    gnt("R6 s1", 8'h0F, 1'b1, 3'd1);
    gnt("R6 s2", 8'h0F, 1'b1, 3'd2);
    gnt("R6 s3", 8'h0F, 1'b1, 3'd3);
    gnt("R6 s4", 8'h0F, 1'b1, 3'd3);
    gnt("R6 s5", 8'h0F, 1'b1, 3'd3);
    gnt("R2 wrap len6", 8'h0F, 1'b1, 3'd0);

    // R9: accepted write, then a write during busy, then one without bit 15
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 16'h8155;
    @(posedge clk);
    #1;
    chk("R9 busy after accept", int'(cfg_busy), 1);
    @(negedge clk);
    cfg_wdata = 16'h80FF;
    @(posedge clk);
    #1;
    chk("R9 write while busy no busy", int'(cfg_busy), 0);
    @(negedge clk);
    cfg_wdata = 16'h00FF;
    @(posedge clk);
    #1;
    chk("R9 no update bit no busy", int'(cfg_busy), 0);
    @(negedge clk);
    cfg_we = 1'b0;

    // R11 out-of-range group, R8 illegal lengths, then legal length 6
    wr("R11 grp 0x21", 16'hA1FF);
    wr("R8 len0", 16'hA000);
    wr("R8 len200", 16'hA0C8);
    wr("R8 len6 again", 16'hA006);
    gnt("R9 s0 kept", 8'h0F, 1'b1, 3'd0);
    gnt("R9 s1", 8'h0F, 1'b1, 3'd1);
    gnt("R9 s2", 8'h0F, 1'b1, 3'd2);
    gnt("R9 s3 kept", 8'h0F, 1'b1, 3'd3);
    gnt("R9/R11 s4", 8'h0F, 1'b1, 3'd1);
    gnt("R9/R11 s5", 8'h0F, 1'b1, 3'd1);
    gnt("R8 wrap", 8'h0F, 1'b1, 3'd0);

    // R7 wide mode: slots 7,5,6,0 ; length 3 (selector 0x40)
    @(negedge clk);
    mode_wide = 1'b1;
    wr("R7 g0", 16'h8057);
    wr("R7 g1", 16'h8106);
    wr("R8 wide len3", 16'hC003);
    gnt("R7 s0", 8'hFF, 1'b1, 3'd7);
    gnt("R7 s1", 8'hFF, 1'b1, 3'd5);
    gnt("R7 s2", 8'hFF, 1'b1, 3'd6);
    gnt("R7 wrap", 8'hFF, 1'b1, 3'd7);
    gnt("R3 wide skip", 8'h40, 1'b1, 3'd6);
    gnt("R3 wide wrap skip", 8'h20, 1'b1, 3'd5);

    // R1: reset restores the boot table
    @(negedge clk);
    mode_wide = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 re-reset vld", int'(grant_vld), 0);
    chk("R1 re-reset busy", int'(cfg_busy), 0);
    @(negedge clk);
    rst = 1'b0;
    gnt("R1 boot s0", 8'h0F, 1'b1, 3'd3);
    gnt("R1 boot s1", 8'h0F, 1'b1, 3'd2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule